// File: doc/BRIEF.md
# Deferred Condition-Flag Evaluator

This block rebuilds the four condition flags (negative, zero, carry, overflow) from a stored record of the last flag-setting operation. It does not track flags after every instruction. The record holds a 4-bit operation code and three dependency words, and their meaning depends on the code. The evaluator turns them into flags only when a consumer asks for them. A consumer might be a conditional branch, a flag read, or a context save.

Results come out in two forms at the same time. The first is a packed word, with the four flags in its top four bits and zeros below them. The second is a single chosen flag on a one-bit output. An error output flags records that cannot be interpreted, and in that case every flag output reads zero. With `REGISTERED=1` (the default) the outputs are registered: `out_valid` follows `in_valid` by one clock, and a synchronous active-high reset clears the outputs. With `REGISTERED=0` the outputs follow the inputs in the same cycle.

Top module: `cc_flag_eval`

## Requirements
- R1: While `rst` is high at a clock edge, the registered outputs clear: `out_valid`, `op_err`, `flag_bit` and all of `flags_packed` read 0.
- R2: In registered mode the outputs present the result for the inputs sampled with `in_valid` high one clock earlier, and `out_valid` is high exactly in that cycle. In combinational mode the outputs follow the inputs in the same cycle.
- R3: Code 0 (copy): dependency word A already holds the flags in bits 31..28, ordered N, Z, C, V from high to low, and each flag is taken from its own position.
- R4: Code 1 (add): the result is A+B. C is set when the 32-bit result is unsigned-below A. V is bit 31 of (res^A)&(res^B).
- R5: Code 2 (subtract): the result is A−B. C is the not-borrow flag, which is A ≥ B unsigned. V is bit 31 of (A^B)&(A^res).
- R6: Code 3 (add with carry): word C is the carry-in (0 or 1) and the result is A+B+cin. C is set when res ≤ A if cin=1, and when res < A if cin=0. V follows the add rule.
- R7: Code 4 (subtract with carry): the result is A−B−(cin XOR 1). C is set when A ≥ B if cin=1, and when A > B if cin=0. V follows the subtract rule.
- R8: Code 5 (logical): word A is the result, word B (0 or 1) becomes C, and word C (0 or 1) is the previous V, passed through unchanged.
- R9: Code 6 (multiply): word A is the result. Word C carries the previous C in bit 1 and the previous V in bit 0, and both pass through unchanged.
- R10: Code 7 (long multiply): word A is the low half and word B is the high half. N is bit 31 of the high half, Z is set only when both halves are zero, and C and V come from word C as for code 6.
- R11: For codes 1 to 6, N is bit 31 of the result and Z is set exactly when the result is zero.
- R12: `flags_packed` holds N, Z, C and V in bits 31, 30, 29 and 28, with bits 27..0 zero. `flag_sel` values 0, 1, 2 and 3 place N, Z, C or V on `flag_bit`.
- R13: `op_err` is raised, and every flag output reads 0, for any of these: a code from 8 to 15, a carry-in above 1 for codes 3 and 4, word B or word C above 1 for code 5, or word C above 3 for codes 6 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request for evaluation of the presented record |
| op_code | input | 4 | Kind of the recorded operation |
| dep_a | input | W | Dependency word A |
| dep_b | input | W | Dependency word B |
| dep_c | input | W | Dependency word C |
| flag_sel | input | 2 | Picks which single flag drives `flag_bit` |
| out_valid | output | 1 | Result present on the outputs |
| flags_packed | output | W | N, Z, C, V in the top four bits, zeros below |
| flag_bit | output | 1 | The selected flag |
| op_err | output | 1 | Record could not be interpreted |

## Verification
The assertions check flags only in cycles where `op_err` is low. For that reason they assume nothing about the range of the incoming carry or pass-through operands, and no legal combination is excluded. The pass-through checks for codes 5 to 7 rely on a clean record having its operand bits inside the allowed width, which the guard enforces. The directed stimulus sends mostly clean records at each code's edge values: wrap to zero, signed overflow, equal operands, and both carry-in values. A separate error scenario then sends out-of-range operands and unknown codes on purpose and expects zeroed flags.

// File: rtl/cc_flag_pkg.sv
package cc_flag_pkg;
  typedef enum logic [3:0] {
    OP_COPY  = 4'd0,
    OP_ADD   = 4'd1,
    OP_SUB   = 4'd2,
    OP_ADC   = 4'd3,
    OP_SBB   = 4'd4,
    OP_LOGIC = 4'd5,
    OP_MUL   = 4'd6,
    OP_MULL  = 4'd7
  } cc_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  localparam int unsigned FLAG_COUNT = 4;
endpackage

// File: rtl/cc_addsub.sv
module cc_addsub #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] lhs,
  input  logic [W-1:0] rhs,
  input  logic         cin,
  input  logic         sub,
  output logic [W-1:0] res,
  output logic         carry,
  output logic         ovf
);
  localparam int unsigned MSB = W - 1;

  // Subtraction is done as lhs + ~rhs + cin; the carry-out is then not-borrow.
  function automatic logic [W:0] add_wide(input logic [W-1:0] x, input logic [W-1:0] y,
                                          input logic ci);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
  endfunction

  // Signed overflow: operands share a sign and the result sign differs.
  function automatic logic sign_ovf(input logic xs, input logic ys, input logic rs);
    return (xs == ys) && (rs != xs);
  endfunction

  logic [W-1:0] rhs_eff;
  logic [W:0]   sum_w;

  always_comb begin
    rhs_eff = sub ? ~rhs : rhs;
    sum_w   = add_wide(lhs, rhs_eff, cin);
    res     = sum_w[W-1:0];
    carry   = sum_w[W];
    ovf     = sign_ovf(lhs[MSB], rhs_eff[MSB], sum_w[MSB]);
  end
endmodule

// File: rtl/cc_op_guard.sv
module cc_op_guard
  import cc_flag_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [3:0]   op_code,
  input  logic [W-1:0] dep_b,
  input  logic [W-1:0] dep_c,
  output logic         bad_code,
  output logic         bad_operand
);
  // True when any bit at or above position keep is set.
  function automatic logic above(input logic [W-1:0] x, input int unsigned keep);
    return (x >> keep) != '0;
  endfunction

  always_comb begin
    bad_code    = 1'b0;
    bad_operand = 1'b0;
    unique case (op_code)
      OP_COPY, OP_ADD, OP_SUB: ;
      OP_ADC, OP_SBB:          bad_operand = above(dep_c, 1);
      OP_LOGIC:                bad_operand = above(dep_b, 1) || above(dep_c, 1);
      OP_MUL, OP_MULL:         bad_operand = above(dep_c, 2);
      default:                 bad_code = 1'b1;
    endcase
  end
endmodule

// File: rtl/cc_flag_eval.sv
module cc_flag_eval
  import cc_flag_pkg::*;
#(
  parameter int unsigned W          = 32,
  parameter bit          REGISTERED = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [3:0]   op_code,
  input  logic [W-1:0] dep_a,
  input  logic [W-1:0] dep_b,
  input  logic [W-1:0] dep_c,
  input  logic [1:0]   flag_sel,
  output logic         out_valid,
  output logic [W-1:0] flags_packed,
  output logic         flag_bit,
  output logic         op_err
);
  localparam int unsigned MSB = W - 1;
  localparam int unsigned PAD = W - FLAG_COUNT;

  logic         as_sub, as_cin;
  logic [W-1:0] as_res;
  logic         as_carry, as_ovf;
  logic         bad_code, bad_operand, err_now;
  nzcv_t        raw_f, eval_f;
  logic [W-1:0] packed_now;
  logic         bit_now;

  always_comb begin
    as_sub = (op_code == OP_SUB) || (op_code == OP_SBB);
    unique case (op_code)
      OP_SUB:         as_cin = 1'b1;
      OP_ADC, OP_SBB: as_cin = dep_c[0];
      default:        as_cin = 1'b0;
    endcase
  end

  cc_addsub #(.W(W)) u_addsub (
    .lhs(dep_a), .rhs(dep_b), .cin(as_cin), .sub(as_sub),
    .res(as_res), .carry(as_carry), .ovf(as_ovf)
  );

  cc_op_guard #(.W(W)) u_guard (
    .op_code(op_code), .dep_b(dep_b), .dep_c(dep_c),
    .bad_code(bad_code), .bad_operand(bad_operand)
  );

  always_comb begin
    raw_f = '0;
    unique case (op_code)
      OP_COPY: raw_f = dep_a[MSB -: FLAG_COUNT];
      OP_ADD, OP_SUB, OP_ADC, OP_SBB:
        raw_f = '{n: as_res[MSB], z: (as_res == '0), c: as_carry, v: as_ovf};
      OP_LOGIC:
        raw_f = '{n: dep_a[MSB], z: (dep_a == '0), c: dep_b[0], v: dep_c[0]};
      OP_MUL:
        raw_f = '{n: dep_a[MSB], z: (dep_a == '0), c: dep_c[1], v: dep_c[0]};
      OP_MULL:
        raw_f = '{n: dep_b[MSB], z: ((dep_a | dep_b) == '0), c: dep_c[1], v: dep_c[0]};
      default: raw_f = '0;
    endcase
    err_now    = bad_code || bad_operand;
    eval_f     = err_now ? '0 : raw_f;
    packed_now = {eval_f, {PAD{1'b0}}};
    bit_now    = eval_f[FLAG_COUNT - 1 - flag_sel];
  end

  generate
    if (REGISTERED) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          out_valid    <= 1'b0;
          flags_packed <= '0;
          flag_bit     <= 1'b0;
          op_err       <= 1'b0;
        end else begin
          out_valid    <= in_valid;
          flags_packed <= packed_now;
          flag_bit     <= bit_now;
          op_err       <= err_now;
        end
      end
    end else begin : g_comb
      always_comb begin
        out_valid    = in_valid;
        flags_packed = packed_now;
        flag_bit     = bit_now;
        op_err       = err_now;
      end
    end
  endgenerate
endmodule

// File: rtl/cc_flag_eval_chk.sv
module cc_flag_eval_chk #(
  parameter int unsigned W          = 32,
  parameter bit          REGISTERED = 1'b1
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic [3:0]   op_code,
  input logic [1:0]   old_cv,
  input logic [1:0]   flag_sel,
  input logic         out_valid,
  input logic [W-1:0] flags_packed,
  input logic         flag_bit,
  input logic         op_err
);
  localparam int unsigned MSB = W - 1;

  logic n_o, z_o, c_o, v_o;
  assign n_o = flags_packed[MSB];
  assign z_o = flags_packed[MSB-1];
  assign c_o = flags_packed[MSB-2];
  assign v_o = flags_packed[MSB-3];

  generate
    if (REGISTERED) begin : g_chk
      // R2: valid tracks the request with one cycle of latency
      a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
      a_r2_idle_follows: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
      // R13: an error zeroes every flag output
      a_r13_err_zero: assert property (@(posedge clk) disable iff (rst)
        op_err |-> (flags_packed == '0) && !flag_bit);
      // R12: the single flag matches its packed position
      a_r12_sel_match: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> flag_bit == flags_packed[MSB - $past(flag_sel)]);
      // R12: bits below the flags stay zero
      a_r12_low_zero: assert property (@(posedge clk) disable iff (rst)
        flags_packed[MSB-4:0] == '0);
      // R11: outside copy, a zero result cannot be negative
      a_r11_nz_exclusive: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_code != 4'd0) |=> !(n_o && z_o));
      // R9: multiply passes the previous C and V through
      a_r9_mul_pass: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_code == 4'd6) |=> op_err || (c_o == $past(old_cv[1]) && v_o == $past(old_cv[0])));
    end
  endgenerate
endmodule

bind cc_flag_eval cc_flag_eval_chk #(.W(W), .REGISTERED(REGISTERED)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op_code(op_code),
  .old_cv(dep_c[1:0]), .flag_sel(flag_sel), .out_valid(out_valid),
  .flags_packed(flags_packed), .flag_bit(flag_bit), .op_err(op_err)
);

// File: tb/tb_cc_flag_eval.sv
module tb_cc_flag_eval;
  localparam int unsigned W = 32;
  localparam time CLK_PERIOD = 10ns;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [3:0]   op_code = '0;
  logic [W-1:0] dep_a = '0, dep_b = '0, dep_c = '0;
  logic [1:0]   flag_sel = '0;
  logic         out_valid, flag_bit, op_err;
  logic [W-1:0] flags_packed;
  logic         c_valid, c_bit, c_err;
  logic [W-1:0] c_packed;

  int checks = 0;
  int errors = 0;
  logic [1:0] sel_rot = '0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cc_flag_eval #(.W(W), .REGISTERED(1'b1)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_code(op_code),
    .dep_a(dep_a), .dep_b(dep_b), .dep_c(dep_c), .flag_sel(flag_sel),
    .out_valid(out_valid), .flags_packed(flags_packed), .flag_bit(flag_bit), .op_err(op_err)
  );

  cc_flag_eval #(.W(W), .REGISTERED(1'b0)) dut_comb (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_code(op_code),
    .dep_a(dep_a), .dep_b(dep_b), .dep_c(dep_c), .flag_sel(flag_sel),
    .out_valid(c_valid), .flags_packed(c_packed), .flag_bit(c_bit), .op_err(c_err)
  );

  // Reference from the requirement text: {err, N, Z, C, V}
  function automatic logic [4:0] ref_eval(input logic [3:0] op, input logic [31:0] a,
                                          input logic [31:0] b, input logic [31:0] c);
    logic [31:0] r;
    logic e, n, z, cf, v;
    e = 0; n = 0; z = 0; cf = 0; v = 0; r = '0;
    case (op)
      4'd0: begin n = a[31]; z = a[30]; cf = a[29]; v = a[28]; end
      4'd1: begin r = a + b; cf = r < a; v = ((r ^ a) & (r ^ b)) >> 31; end
      4'd2: begin r = a - b; cf = a >= b; v = ((a ^ b) & (a ^ r)) >> 31; end
      4'd3: begin e = c > 1; r = a + b + c; cf = c[0] ? (r <= a) : (r < a);
                  v = ((r ^ a) & (r ^ b)) >> 31; end
      4'd4: begin e = c > 1; r = a - b - (c ^ 1); cf = c[0] ? (a >= b) : (a > b);
                  v = ((a ^ b) & (a ^ r)) >> 31; end
      4'd5: begin e = (b > 1) || (c > 1); r = a; cf = b[0]; v = c[0]; end
      4'd6: begin e = c > 3; r = a; cf = c[1]; v = c[0]; end
      4'd7: begin e = c > 3; n = b[31]; z = (a | b) == 0; cf = c[1]; v = c[0]; end
      default: e = 1;
    endcase
    if (op >= 4'd1 && op <= 4'd6) begin n = r[31]; z = (r == 0); end
    if (e) return 5'b10000;
    return {1'b0, n, z, cf, v};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  // Drive one record; check the same-cycle variant, then the registered one.
  task automatic apply(input string req, input logic [3:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic [31:0] c);
    logic [4:0] e;
    logic [31:0] exp_packed;
    logic exp_bit;
    e = ref_eval(op, a, b, c);
    exp_packed = {e[3:0], 28'h0};
    exp_bit = e[3 - sel_rot];
    @(negedge clk);
    op_code = op; dep_a = a; dep_b = b; dep_c = c; flag_sel = sel_rot; in_valid = 1'b1;
    #1;
    chk({req, " R2"}, "comb flags", c_packed, exp_packed);
    chk({req, " R2"}, "comb err", {31'h0, c_err}, {31'h0, e[4]});
    @(negedge clk);
    in_valid = 1'b0;
    chk(req, "valid", {31'h0, out_valid}, 32'h1);
    chk(req, "flags", flags_packed, exp_packed);
    chk({req, " R12"}, "flag_bit", {31'h0, flag_bit}, {31'h0, exp_bit});
    chk({req, " R13"}, "err", {31'h0, op_err}, {31'h0, e[4]});
    sel_rot = sel_rot + 2'd1;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1", "valid", {31'h0, out_valid}, 32'h0);
    chk("R1", "flags", flags_packed, 32'h0);
    chk("R1", "err/bit", {30'h0, op_err, flag_bit}, 32'h0);
  endtask

  task automatic t_copy;
    apply("R3", 4'd0, 32'hA000_0000, 0, 0);
    apply("R3", 4'd0, 32'h5000_0000, 0, 0);
    apply("R3", 4'd0, 32'hF000_0000, 32'h1234, 32'h9);
  endtask

  task automatic t_add;
    apply("R4", 4'd1, 32'h7FFF_FFFF, 32'h1, 0);
    apply("R4", 4'd1, 32'hFFFF_FFFF, 32'h1, 0);
    apply("R4 R11", 4'd1, 32'h8000_0000, 32'h8000_0000, 0);
    apply("R4", 4'd1, 32'h1234_5678, 32'h0101_0101, 0);
  endtask

  task automatic t_sub;
    apply("R5 R11", 4'd2, 32'h5, 32'h5, 0);
    apply("R5", 4'd2, 32'h0, 32'h1, 0);
    apply("R5", 4'd2, 32'h8000_0000, 32'h1, 0);
    apply("R5", 4'd2, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 0);
  endtask

  task automatic t_adc;
    apply("R6", 4'd3, 32'hFFFF_FFFF, 32'h0, 32'h1);
    apply("R6", 4'd3, 32'hFFFF_FFFF, 32'h0, 32'h0);
    apply("R6", 4'd3, 32'h7FFF_FFFF, 32'h0, 32'h1);
    apply("R6", 4'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h1);
  endtask

  task automatic t_sbb;
    apply("R7", 4'd4, 32'h9, 32'h9, 32'h0);
    apply("R7", 4'd4, 32'h9, 32'h9, 32'h1);
    apply("R7", 4'd4, 32'h8000_0000, 32'h0, 32'h0);
    apply("R7", 4'd4, 32'hA, 32'h3, 32'h0);
  endtask

  task automatic t_logic;
    apply("R8", 4'd5, 32'h0, 32'h1, 32'h0);
    apply("R8", 4'd5, 32'h8000_0001, 32'h0, 32'h1);
  endtask

  task automatic t_mul;
    apply("R9", 4'd6, 32'h0, 0, 32'h2);
    apply("R9", 4'd6, 32'hC000_0000, 32'hFFFF, 32'h1);
  endtask

  task automatic t_mull;
    apply("R10", 4'd7, 32'h0, 32'h0, 32'h3);
    apply("R10", 4'd7, 32'h1, 32'h0, 32'h0);
    apply("R10", 4'd7, 32'h0, 32'h8000_0000, 32'h2);
  endtask

  task automatic t_error;
    apply("R13", 4'd8, 32'hF000_0000, 0, 0);
    apply("R13", 4'd15, 32'h0, 0, 0);
    apply("R13", 4'd3, 32'hFFFF_FFFF, 32'h1, 32'h2);
    apply("R13", 4'd5, 32'h8000_0000, 32'h2, 32'h1);
    apply("R13", 4'd6, 32'h8000_0000, 0, 32'h4);
    apply("R13", 4'd7, 32'h0, 32'h8000_0000, 32'h8000_0003);
  endtask

  task automatic t_pipeline;
    // Back-to-back requests, then one idle cycle
    @(negedge clk);
    op_code = 4'd2; dep_a = 32'h3; dep_b = 32'h3; dep_c = 0; flag_sel = 2'd1; in_valid = 1'b1;
    @(negedge clk);
    chk("R2", "first result", flags_packed, 32'h6000_0000);
    chk("R2", "first bit", {31'h0, flag_bit}, 32'h1);
    op_code = 4'd0; dep_a = 32'h9000_0000; flag_sel = 2'd3;
    @(negedge clk);
    chk("R2", "second result", flags_packed, 32'h9000_0000);
    chk("R2", "second bit", {31'h0, flag_bit}, 32'h1);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R2", "idle valid", {31'h0, out_valid}, 32'h0);
    chk("R2", "comb idle", {31'h0, c_valid}, 32'h0);
  endtask

  task automatic t_reset_mid;
    @(negedge clk);
    op_code = 4'd0; dep_a = 32'hF000_0000; flag_sel = 2'd0; in_valid = 1'b1;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1", "valid in reset", {31'h0, out_valid}, 32'h0);
    chk("R1", "flags in reset", flags_packed, 32'h0);
    in_valid = 1'b0; rst = 1'b0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk);
    rst = 1'b0;
    t_copy();
    t_add();
    t_sub();
    t_adc();
    t_sbb();
    t_logic();
    t_mul();
    t_mull();
    t_error();
    t_pipeline();
    t_reset_mid();
    finish_run();
  end
endmodule